// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit carries out a byte-wise table lookup on 128-bit vectors in a single combinational pass. A decoded instruction word names a destination register, an index register and the first of a run of one to four table registers in a 32-entry vector register file. The unit drives the read addresses of that file and takes the read data back in the same cycle. For every byte lane of the index vector, it picks one byte out of the table formed by joining the run of registers.

Lanes whose index points past the end of the table take a fallback value. In the plain variant the fallback is zero. In the merge variant it is the byte already held in the destination register. A half-width mode handles only the low 64 bits of the index and writes zero into the upper half of the result. A write-enable, the destination number and the 128-bit result are driven in the same cycle as a valid instruction. An encoding with reserved bits set raises a flag and writes nothing.

Top module: `vtbl_unit`

## Requirements
- R1: When `instr_valid` is 1 and bits [23:22] are zero, `wr_en` is 1 and `wr_addr` equals instruction bits [4:0].
- R2: Table slot k (k = 0..3) is read at address `tbl_raddr[5k+4:5k]` = (bits [9:5] + k) mod 32, so the register number wraps from 31 to 0. Table byte t is byte t mod 16 (byte b = bits 8b+7:8b) of slot t/16, with its data on `tbl_rdata[128k+127:128k]`.
- R3: The index register is read at `idx_raddr` = bits [20:16]. Result lane i uses index byte i (`idx_rdata` bits 8i+7:8i).
- R4: The table holds bits [14:13] + 1 registers. A processed lane whose index is below 16 × (that count) takes the table byte at that index.
- R5: With bit 12 clear, a processed lane whose index is at or above 16 × the register count gives 0x00. This includes index 0xFF.
- R6: With bit 12 set, such an out-of-range lane keeps the destination's current byte, which is read at `old_raddr` = bits [4:0].
- R7: With bit 30 clear, only lanes 0..7 are processed, and bits [127:64] of `wr_data` are zero even in the merge variant. With bit 30 set, all 16 lanes are processed.
- R8: When `instr_valid` is 1 and bits [23:22] are not zero, `unalloc` is 1 and `wr_en` is 0.
- R9: When `instr_valid` is 0, `wr_en` and `unalloc` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| tbl_raddr | output | 20 | Read addresses of the four table slots, slot 0 lowest |
| tbl_rdata | input | 512 | Read data of the four table slots, slot 0 lowest |
| idx_raddr | output | 5 | Read address of the index register |
| idx_rdata | input | 128 | Index register contents |
| old_raddr | output | 5 | Read address of the destination register |
| old_rdata | input | 128 | Current destination contents |
| wr_en | output | 1 | Write the result to the destination |
| wr_addr | output | 5 | Destination register number |
| wr_data | output | 128 | Result value |
| unalloc | output | 1 | Reserved bits set in a valid instruction |

## Verification
Index bytes are drawn from four pools: fully random, inside the 64-byte ceiling, exactly at 16n-1 and 16n for the current length, and 0xFF. The boundary pool separates a correct bound compare from an off-by-one. The 0xFF pool shows that high indices are not folded back into the table. The run is random over all lengths, both widths and both variants, with register files that differ per case, so zero-fill can be told apart from merge and slot wrap-around is exercised. Directed cases cover a run starting at register 30, half-width merge, a reserved encoding and an idle cycle.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
   localparam int INSN_W    = 32;
   localparam int REGNUM_W  = 5;
   localparam int LEN_W     = 2;
   localparam int DST_LSB   = 0;
   localparam int FIRST_LSB = 5;
   localparam int IDX_LSB   = 16;
   localparam int LEN_LSB   = 13;
   localparam int MERGE_POS = 12;
   localparam int FULL_POS  = 30;
   localparam int RSV_LSB   = 22;
   localparam int RSV_W     = 2;

   typedef struct packed {
      logic [REGNUM_W-1:0] dst;
      logic [REGNUM_W-1:0] first;
      logic [REGNUM_W-1:0] idx;
      logic [LEN_W-1:0]    len;
      logic                merge;
      logic                full;
      logic                reserved;
   } lookup_op_t;
endpackage

// File: rtl/vtbl_decode.sv
module vtbl_decode
   import vtbl_pkg::*;
(
   input  logic [INSN_W-1:0] instr,
   output lookup_op_t        op
);
   always_comb begin
      op.dst      = instr[DST_LSB   +: REGNUM_W];
      op.first    = instr[FIRST_LSB +: REGNUM_W];
      op.idx      = instr[IDX_LSB   +: REGNUM_W];
      op.len      = instr[LEN_LSB   +: LEN_W];
      op.merge    = instr[MERGE_POS];
      op.full     = instr[FULL_POS];
      op.reserved = |instr[RSV_LSB +: RSV_W];
   end
endmodule

// File: rtl/vtbl_addrgen.sv
module vtbl_addrgen #(
   parameter int AW      = 5,
   parameter int MAX_TBL = 4
) (
   input  logic [AW-1:0]         first,
   output logic [MAX_TBL*AW-1:0] addr
);
   for (genvar k = 0; k < MAX_TBL; k++) begin : g_slot
      localparam logic [AW-1:0] OFS = AW'(k);
      // modular add: wraps past the last register
      assign addr[k*AW +: AW] = first + OFS;
   end
endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane #(
   parameter int NBYTES  = 16,
   parameter int MAX_TBL = 4,
   localparam int TBL_BYTES = NBYTES * MAX_TBL,
   localparam int SEL_W     = $clog2(TBL_BYTES),
   localparam int CNT_W     = $clog2(MAX_TBL + 1)
) (
   input  logic [7:0]             idx,
   input  logic [TBL_BYTES*8-1:0] table_bytes,
   input  logic [CNT_W-1:0]       nregs,
   input  logic [7:0]             fallback,
   input  logic                   active,
   output logic [7:0]             res
);
   localparam int LIM_W = 16;

   logic [LIM_W-1:0] limit;
   logic             in_range;
   logic [SEL_W-1:0] sel;

   always_comb begin
      limit    = LIM_W'(nregs) * LIM_W'(NBYTES);
      in_range = LIM_W'(idx) < limit;
      sel      = idx[SEL_W-1:0];
      if (!active)
         res = 8'h00;
      else if (in_range)
         res = table_bytes[sel*8 +: 8];
      else
         res = fallback;
   end
endmodule

// File: rtl/vtbl_unit.sv
module vtbl_unit
   import vtbl_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int AW      = 5,
   parameter int MAX_TBL = 4
) (
   input  logic                     instr_valid,
   input  logic [31:0]              instr,
   output logic [MAX_TBL*AW-1:0]    tbl_raddr,
   input  logic [MAX_TBL*VEC_W-1:0] tbl_rdata,
   output logic [AW-1:0]            idx_raddr,
   input  logic [VEC_W-1:0]         idx_rdata,
   output logic [AW-1:0]            old_raddr,
   input  logic [VEC_W-1:0]         old_rdata,
   output logic                     wr_en,
   output logic [AW-1:0]            wr_addr,
   output logic [VEC_W-1:0]         wr_data,
   output logic                     unalloc
);
   localparam int NBYTES = VEC_W / 8;
   localparam int HALF   = NBYTES / 2;
   localparam int CNT_W  = $clog2(MAX_TBL + 1);

   if (VEC_W % 128 != 0 || VEC_W / 128 != 1) begin : g_bad_width
      $error("vtbl_unit: VEC_W must be 128");
   end
   if (AW != REGNUM_W) begin : g_bad_aw
      $error("vtbl_unit: AW must match the register field width");
   end
   if (MAX_TBL != (1 << LEN_W)) begin : g_bad_tbl
      $error("vtbl_unit: MAX_TBL must cover every length code");
   end
   if (NBYTES * MAX_TBL > 256) begin : g_bad_reach
      $error("vtbl_unit: table larger than an index byte can reach");
   end

   lookup_op_t       op;
   logic [CNT_W-1:0] nregs;

   vtbl_decode u_decode (
      .instr (instr),
      .op    (op)
   );

   vtbl_addrgen #(.AW(AW), .MAX_TBL(MAX_TBL)) u_addrgen (
      .first (op.first),
      .addr  (tbl_raddr)
   );

   assign idx_raddr = op.idx;
   assign old_raddr = op.dst;
   assign nregs     = CNT_W'(op.len) + CNT_W'(1);

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic       act;
      logic [7:0] fb;
      if (i < HALF) begin : g_low
         assign act = 1'b1;
      end else begin : g_high
         assign act = op.full;
      end
      assign fb = op.merge ? old_rdata[i*8 +: 8] : 8'h00;

      vtbl_lane #(.NBYTES(NBYTES), .MAX_TBL(MAX_TBL)) u_lane (
         .idx         (idx_rdata[i*8 +: 8]),
         .table_bytes (tbl_rdata),
         .nregs       (nregs),
         .fallback    (fb),
         .active      (act),
         .res         (wr_data[i*8 +: 8])
      );
   end

   assign wr_en   = instr_valid & ~op.reserved;
   assign unalloc = instr_valid &  op.reserved;
   assign wr_addr = op.dst;
endmodule

// File: rtl/vtbl_checker.sv
module vtbl_checker #(
   parameter int VEC_W   = 128,
   parameter int AW      = 5,
   parameter int MAX_TBL = 4
) (
   input logic                     instr_valid,
   input logic [31:0]              instr,
   input logic [MAX_TBL*AW-1:0]    tbl_raddr,
   input logic [MAX_TBL*VEC_W-1:0] tbl_rdata,
   input logic [AW-1:0]            idx_raddr,
   input logic [VEC_W-1:0]         idx_rdata,
   input logic [AW-1:0]            old_raddr,
   input logic [VEC_W-1:0]         old_rdata,
   input logic                     wr_en,
   input logic [AW-1:0]            wr_addr,
   input logic [VEC_W-1:0]         wr_data,
   input logic                     unalloc
);
   localparam int NB = VEC_W / 8;

   always_comb begin
      if (unalloc)
         assert_unalloc_no_write_R8: assert (!wr_en);
      if (!instr_valid)
         assert_idle_quiet_R9: assert (!wr_en && !unalloc);
      if (wr_en && !instr[30])
         assert_high_clear_R7: assert (wr_data[VEC_W-1:VEC_W/2] == '0);
      for (int i = 0; i < NB; i++) begin
         if (wr_en && (instr[30] || i < NB/2)) begin
            if (int'(idx_rdata[i*8 +: 8]) >= 16 * (int'(instr[14:13]) + 1)) begin
               if (instr[12])
                  assert_oor_keep_R6: assert (wr_data[i*8 +: 8] == old_rdata[i*8 +: 8]);
               else
                  assert_oor_zero_R5: assert (wr_data[i*8 +: 8] == 8'h00);
            end else begin
               assert_inrange_pick_R4: assert (wr_data[i*8 +: 8] ==
                                             tbl_rdata[int'(idx_rdata[i*8 +: 8])*8 +: 8]);
            end
         end
      end
   end
endmodule

bind vtbl_unit vtbl_checker u_chk (.*);

// File: tb/vtbl_unit_bench.sv
`timescale 1ns/1ps
module vtbl_unit_bench;
   logic         clk = 1'b0;
   logic         instr_valid;
   logic [31:0]  instr;
   logic [19:0]  tbl_raddr;
   logic [511:0] tbl_rdata;
   logic [4:0]   idx_raddr;
   logic [127:0] idx_rdata;
   logic [4:0]   old_raddr;
   logic [127:0] old_rdata;
   logic         wr_en;
   logic [4:0]   wr_addr;
   logic [127:0] wr_data;
   logic         unalloc;

   logic [127:0] rf [32];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   assign tbl_rdata = {rf[tbl_raddr[19:15]], rf[tbl_raddr[14:10]],
                       rf[tbl_raddr[9:5]],   rf[tbl_raddr[4:0]]};
   assign idx_rdata = rf[idx_raddr];
   assign old_rdata = rf[old_raddr];

   vtbl_unit u_vtbl_unit (
      .instr_valid (instr_valid), .instr (instr),
      .tbl_raddr (tbl_raddr), .tbl_rdata (tbl_rdata),
      .idx_raddr (idx_raddr), .idx_rdata (idx_rdata),
      .old_raddr (old_raddr), .old_rdata (old_rdata),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .unalloc (unalloc)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_byte(logic [31:0] ins, int lane);
      int n = int'(ins[14:13]) + 1;
      int b = int'(rf[ins[20:16]][lane*8 +: 8]);
      logic [4:0] r;
      if (lane >= 8 && !ins[30]) return 8'h00;
      if (b < 16 * n) begin
         r = ins[9:5] + 5'(b / 16);
         return rf[r][(b % 16)*8 +: 8];
      end
      return ins[12] ? rf[ins[4:0]][lane*8 +: 8] : 8'h00;
   endfunction

   task automatic run_case(input logic v, input logic [31:0] ins);
      logic ok;
      @(posedge clk);
      instr_valid = v;
      instr       = ins;
      @(negedge clk);
      ok = v && (ins[23:22] == 2'b00);
      chk(v ? (ok ? "R1" : "R8") : "R9", {127'd0, wr_en}, {127'd0, ok});
      chk(v ? "R8" : "R9", {127'd0, unalloc}, {127'd0, v && !ok});
      for (int k = 0; k < 4; k++)
         chk("R2", {123'd0, tbl_raddr[k*5 +: 5]}, {123'd0, 5'(ins[9:5] + 5'(k))});
      chk("R3", {123'd0, idx_raddr}, {123'd0, ins[20:16]});
      chk("R6", {123'd0, old_raddr}, {123'd0, ins[4:0]});
      if (ok) begin
         chk("R1", {123'd0, wr_addr}, {123'd0, ins[4:0]});
         for (int i = 0; i < 16; i++) begin
            int b = int'(rf[ins[20:16]][i*8 +: 8]);
            string req;
            if (i >= 8 && !ins[30]) req = "R7";
            else if (b < 16 * (int'(ins[14:13]) + 1)) req = "R4";
            else if (ins[12]) req = "R6";
            else req = "R5";
            chk(req, {120'd0, wr_data[i*8 +: 8]}, {120'd0, ref_byte(ins, i)});
         end
      end
   endtask

   task automatic fill_rf();
      for (int r = 0; r < 32; r++)
         rf[r] = {$urandom(), $urandom(), $urandom(), $urandom()};
   endtask

   function automatic logic [31:0] mk(int q, int rm, int len, int mrg, int rn, int rd);
      logic [31:0] w = '0;
      w[30] = q[0]; w[20:16] = rm[4:0]; w[14:13] = len[1:0];
      w[12] = mrg[0]; w[9:5] = rn[4:0]; w[4:0] = rd[4:0];
      return w;
   endfunction

   task automatic set_index(input logic [31:0] ins);
      int n = (int'(ins[14:13]) + 1) * 16;
      logic [127:0] v;
      for (int i = 0; i < 16; i++) begin
         case ($urandom % 4)
            0: v[i*8 +: 8] = 8'($urandom);
            1: v[i*8 +: 8] = 8'(n - 1 + int'($urandom % 2));
            2: v[i*8 +: 8] = 8'hFF;
            default: v[i*8 +: 8] = 8'($urandom % 64);
         endcase
      end
      rf[ins[20:16]] = v;
   endtask

   initial begin
      void'($urandom(32'h1234_5678));
      instr_valid = 1'b0;
      instr       = '0;
      fill_rf();
      // idle: no write, no flag (R9)
      run_case(1'b0, mk(1, 3, 2, 1, 4, 5));
      // wrap past register 31, full, merge (R2, R6)
      fill_rf();
      rf[7] = 128'h00_01_0F_10_1F_20_2F_30_3F_40_FF_3E_11_21_31_05;
      run_case(1'b1, mk(1, 7, 3, 1, 30, 9));
      // one register, bound 15/16, zero fill (R4, R5)
      fill_rf();
      rf[2] = 128'h0F_10_FF_00_0E_11_01_20_0F_10_FF_00_0E_11_01_20;
      run_case(1'b1, mk(1, 2, 0, 0, 12, 2));
      // half width merge: high half must be zero (R7)
      fill_rf();
      rf[6] = {16{8'hFF}};
      run_case(1'b1, mk(0, 6, 1, 1, 20, 8));
      // reserved bits set (R8)
      run_case(1'b1, mk(1, 6, 1, 1, 20, 8) | 32'h0040_0000);
      run_case(1'b1, mk(0, 6, 1, 0, 20, 8) | 32'h00C0_0000);
      // random sweep
      for (int t = 0; t < 400; t++) begin
         logic [31:0] w = $urandom();
         if (($urandom % 10) != 0) w[23:22] = 2'b00;
         fill_rf();
         set_index(w);
         run_case(($urandom % 16) != 0, w);
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule